// File: doc/BRIEF.md
# Double-Buffered TDM Frame Address Generator

This block turns the position of the serial TDM scan (the active channel, the stream index and whether the current byte is fetched or stored) into the 13-bit address of an external dual-port RAM. The RAM is split into two frame blocks. Each block has a transmit region, which the block reads to feed the serial outputs, and a receive region, which it writes with the bytes gathered from the serial inputs. The block fetches transmit bytes two channels ahead of the active channel. It stores receive bytes one channel behind, so at any moment the read and write channels are three apart.

Two block flags, one for reads and one for writes, each flip once per frame when the last byte of that direction has been handled. A host processor watches them to know which half of the RAM it may use while the other half is in use on the TDM side. The rate mode is taken only during reset. It fixes the number of channels per stream, the number of streams per region and the address layout.

Top module: `tdm_dbuf_addr_gen`

## Requirements
- R1: `rate_mode` is captured only while reset is in effect. Later changes have no effect. Encoding: 0 = 2.048 Mb/s (32 channels, 24 streams per region), 1 = 4.096 Mb/s (64 channels, 24 streams), 2 or 3 = 8.192 Mb/s (128 channels, 12 streams per direction).
- R2: After reset, `mem_addr` is 0 and both `rd_block` and `wr_block` are low, so block 0 is used first.
- R3: Transfers offered before the first `frame_sync` pulse after reset are ignored. The address and both flags stay unchanged.
- R4: A read (`xfer_is_rd`=1) addresses the transmit region (direction bit 0) at channel (active+2) mod N.
- R5: A write (`xfer_is_rd`=0) addresses the receive region (direction bit 1) at channel (active−1) mod N.
- R6: The offset inside a region is channel × S + stream, where S is the number of streams per region.
- R7: In the 2.048 Mb/s mode, bit 12 is 0, bit 11 is the block, bit 10 is the direction, and bits 9:0 are the offset.
- R8: In the 4.096 and 8.192 Mb/s modes, bit 12 is the block, bit 11 is the direction, and bits 10:0 are the offset.
- R9: A read uses `rd_block` as its block bit. `rd_block` flips on the same clock edge that registers the read of channel N−1, last stream. The address still carries the old value.
- R10: A write uses `wr_block` as its block bit. `wr_block` flips on the same clock edge that registers the write of channel N−1, last stream. The address still carries the old value.
- R11: `mem_addr` is updated one clock after an accepted transfer and holds its value in any cycle with no accepted transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the byte port |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_mode | input | 2 | Rate mode, captured during reset |
| frame_sync | input | 1 | Frame boundary pulse |
| xfer_vld | input | 1 | A byte transfer is requested this cycle |
| xfer_is_rd | input | 1 | 1 = fetch transmit byte, 0 = store receive byte |
| active_chan | input | 7 | Channel currently on the serial lines |
| stream_sel | input | 5 | Stream index of this transfer |
| mem_addr | output | 13 | Registered RAM address |
| rd_block | output | 1 | Read-side block flag |
| wr_block | output | 1 | Write-side block flag |

## Verification
The assertions assume that `active_chan` stays below the channel count of the captured mode and that `stream_sel` stays below the stream count of the region. They also assume that `frame_sync` is a single-cycle pulse that never coincides with a transfer. The stimulus scans each mode in channel order with stream indices only in the legal range and sends the sync pulse on a cycle of its own. It changes `rate_mode` only at the moments where R1 says the change must be ignored.

// File: rtl/tdm_ag_pkg.sv
package tdm_ag_pkg;

  typedef enum logic [1:0] {
    RATE_2M   = 2'd0,
    RATE_4M   = 2'd1,
    RATE_8M   = 2'd2,
    RATE_8M_B = 2'd3
  } rate_e;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } region_e;

  function automatic logic is_fast(rate_e r);
    return (r == RATE_8M) || (r == RATE_8M_B);
  endfunction

endpackage

// File: rtl/tdm_ag_mode_ctl.sv
module tdm_ag_mode_ctl
  import tdm_ag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  output logic       rst_sync_n,
  output rate_e      rate
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;
  rate_e      rate_q;
  rate_e      rate_d;
  logic       rate_en;

  // reset release synchroniser
  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

  // mode capture, only while reset is still in effect
  always_comb begin
    rate_en = !rst_sync_n;
    rate_d  = rate_e'(mode_in);
  end

  always_ff @(posedge clk) begin
    if (rate_en) rate_q <= rate_d;
  end

  assign rate = rate_q;

  // R1: once out of reset the captured mode never moves
  assert_mode_frozen_R1: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> $stable(rate_q)
  );

endmodule

// File: rtl/tdm_ag_chan_map.sv
module tdm_ag_chan_map
  import tdm_ag_pkg::*;
#(
  parameter int CH_W    = 7,
  parameter int ST_W    = 5,
  parameter int STREAMS = 24,
  parameter int OFF_W   = 11,
  parameter int RD_LEAD = 2,
  parameter int WR_LAG  = 1
) (
  input  rate_e            rate,
  input  logic             is_rd,
  input  logic [CH_W-1:0]  chan,
  input  logic [ST_W-1:0]  stream,
  output logic [OFF_W-1:0] offset,
  output logic             last_slot
);

  localparam int HALF_STREAMS = STREAMS / 2;
  localparam int CH_MAX       = (1 << CH_W) - 1;

  logic [CH_W-1:0] ch_mask;
  logic [ST_W-1:0] st_last;
  logic [CH_W-1:0] ch_shift;
  logic [CH_W-1:0] ch_eff;
  logic            fast;

  always_comb begin
    fast = is_fast(rate);
    unique case (rate)
      RATE_2M: ch_mask = CH_W'(CH_MAX >> 2);
      RATE_4M: ch_mask = CH_W'(CH_MAX >> 1);
      default: ch_mask = CH_W'(CH_MAX);
    endcase
    st_last = fast ? ST_W'(HALF_STREAMS - 1) : ST_W'(STREAMS - 1);

    // read leads the active channel, write trails it; wrap by mode
    ch_shift = is_rd ? (chan + CH_W'(RD_LEAD)) : (chan - CH_W'(WR_LAG));
    ch_eff   = ch_shift & ch_mask;

    if (fast) offset = OFF_W'(ch_eff) * OFF_W'(HALF_STREAMS) + OFF_W'(stream);
    else      offset = OFF_W'(ch_eff) * OFF_W'(STREAMS) + OFF_W'(stream);

    last_slot = (ch_eff == ch_mask) && (stream == st_last);
  end

endmodule

// File: rtl/tdm_ag_blk_flags.sv
module tdm_ag_blk_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_sync,
  input  logic       xfer_vld,
  input  logic       is_rd,
  input  logic       last_slot,
  output logic       accept,
  output logic [1:0] flags      // [0] read side, [1] write side
);

  logic       synced_q;
  logic       synced_d;
  logic [1:0] flag_q;

  always_comb begin
    synced_d = synced_q | frame_sync;
    accept   = synced_q & xfer_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) synced_q <= 1'b0;
    else        synced_q <= synced_d;
  end

  for (genvar d = 0; d < 2; d++) begin : g_side
    logic side_hit;
    logic flag_d;

    always_comb begin
      side_hit = accept && (is_rd == (d == 0)) && last_slot;
      flag_d   = flag_q[d] ^ side_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[d] <= 1'b0;
      else        flag_q[d] <= flag_d;
    end

    // R9 / R10: a flag moves only after the last slot of its own direction
    assert_flag_on_last_R9_R10: assert property (
      @(posedge clk) disable iff (!rst_n)
      !$stable(flag_q[d]) |-> $past(accept && last_slot && (is_rd == (d == 0)))
    );
  end

  // R3: nothing is taken before the first sync pulse
  assert_no_accept_unsynced_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    !synced_q |-> !accept
  );

  assign flags = flag_q;

endmodule

// File: rtl/tdm_dbuf_addr_gen.sv
module tdm_dbuf_addr_gen
  import tdm_ag_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int CH_W    = 7,
  parameter int ST_W    = 5,
  parameter int STREAMS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_mode,
  input  logic              frame_sync,
  input  logic              xfer_vld,
  input  logic              xfer_is_rd,
  input  logic [CH_W-1:0]   active_chan,
  input  logic [ST_W-1:0]   stream_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_block,
  output logic              wr_block
);

  localparam int OFF_W = ADDR_W - 2;

  logic              rst_sync_n;
  rate_e             rate;
  logic [OFF_W-1:0]  offset;
  logic              last_slot;
  logic              accept;
  logic [1:0]        flags;
  logic              blk;
  region_e           dir;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;

  tdm_ag_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_in    (rate_mode),
    .rst_sync_n (rst_sync_n),
    .rate       (rate)
  );

  tdm_ag_chan_map #(
    .CH_W    (CH_W),
    .ST_W    (ST_W),
    .STREAMS (STREAMS),
    .OFF_W   (OFF_W)
  ) u_map (
    .rate      (rate),
    .is_rd     (xfer_is_rd),
    .chan      (active_chan),
    .stream    (stream_sel),
    .offset    (offset),
    .last_slot (last_slot)
  );

  tdm_ag_blk_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_sync (frame_sync),
    .xfer_vld   (xfer_vld),
    .is_rd      (xfer_is_rd),
    .last_slot  (last_slot),
    .accept     (accept),
    .flags      (flags)
  );

  // next address
  always_comb begin
    blk = xfer_is_rd ? flags[0] : flags[1];
    dir = xfer_is_rd ? DIR_TX : DIR_RX;
    if (rate == RATE_2M) addr_d = {1'b0, blk, dir, offset[OFF_W-2:0]};
    else                 addr_d = {blk, dir, offset};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  addr_q <= '0;
    else if (accept)  addr_q <= addr_d;
  end

  assign mem_addr = addr_q;
  assign rd_block = flags[0];
  assign wr_block = flags[1];

  // R7: the top bit is unused in the slow mode
  assert_top_bit_low_R7: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (rate == RATE_2M) |-> !mem_addr[ADDR_W-1]
  );

  // R11: no accepted transfer, no address change
  assert_addr_hold_R11: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    !accept |=> $stable(mem_addr)
  );

  // R4 / R5 / R8: direction bit follows the transfer kind in the wide layout
  assert_dir_bit_R8: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (accept && rate != RATE_2M) |=> (mem_addr[ADDR_W-2] == !$past(xfer_is_rd))
  );

endmodule

// File: tb/tdm_dbuf_addr_gen_test.sv
`timescale 1ns/1ps
module tdm_dbuf_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  rate_mode;
  logic        frame_sync;
  logic        xfer_vld;
  logic        xfer_is_rd;
  logic [6:0]  active_chan;
  logic [4:0]  stream_sel;
  logic [12:0] mem_addr;
  logic        rd_block;
  logic        wr_block;

  always #10 clk = ~clk;

  tdm_dbuf_addr_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_mode   (rate_mode),
    .frame_sync  (frame_sync),
    .xfer_vld    (xfer_vld),
    .xfer_is_rd  (xfer_is_rd),
    .active_chan (active_chan),
    .stream_sel  (stream_sel),
    .mem_addr    (mem_addr),
    .rd_block    (rd_block),
    .wr_block    (wr_block)
  );

  typedef struct {
    logic [12:0] addr;
    logic        rf;
    logic        wf;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference model state
  int          m_rate;
  logic [12:0] m_addr;
  logic        m_rf, m_wf, m_sync;

  function automatic int chans(int r);
    return (r == 0) ? 32 : (r == 1) ? 64 : 128;
  endfunction
  function automatic int strs(int r);
    return (r >= 2) ? 12 : 24;
  endfunction

  task automatic push(string req);
    exp_t e;
    e.addr = m_addr; e.rf = m_rf; e.wf = m_wf; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: one expected item per driven cycle, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, {18'd0, mem_addr, rd_block}, {18'd0, e.addr, e.rf});
      check(e.req, {31'd0, wr_block}, {31'd0, e.wf});
    end
  end

  task automatic idle(string req);
    @(negedge clk);
    xfer_vld = 0; frame_sync = 0;
    push(req);
  endtask

  task automatic pulse();
    @(negedge clk);
    xfer_vld = 0; frame_sync = 1;
    push("R3");
    m_sync = 1;
    @(negedge clk);
    frame_sync = 0;
    push("R11");
  endtask

  // driver: one transfer and its expected result
  task automatic xfer(bit rd, int ch, int st);
    int n, s, ech, off;
    logic blk;
    string req;
    @(negedge clk);
    frame_sync = 0; xfer_vld = 1; xfer_is_rd = rd;
    active_chan = 7'(ch); stream_sel = 5'(st);
    if (!m_sync) begin
      push("R3");
      return;
    end
    n = chans(m_rate); s = strs(m_rate);
    ech = rd ? (ch + 2) % n : (ch - 1 + n) % n;       // R4 R5
    off = ech * s + st;                               // R6
    blk = rd ? m_rf : m_wf;
    if (m_rate == 0) m_addr = 13'((int'(blk) << 11) | ((rd ? 0 : 1) << 10) | off); // R7
    else             m_addr = 13'((int'(blk) << 12) | ((rd ? 0 : 1) << 11) | off); // R8
    req = rd ? "R4 R6 R9" : "R5 R6 R10";
    req = {req, (m_rate == 0) ? " R7" : " R8"};
    if (ech == n - 1 && st == s - 1) begin
      if (rd) m_rf = ~m_rf; else m_wf = ~m_wf;
    end
    push(req);
  endtask

  task automatic do_reset(int mode);
    @(negedge clk);
    rst_n = 0; rate_mode = 2'(mode);
    xfer_vld = 0; frame_sync = 0; xfer_is_rd = 0;
    active_chan = 0; stream_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_rate = mode; m_addr = 0; m_rf = 0; m_wf = 0; m_sync = 0;
    // R2: reset state
    check("R2", {19'd0, mem_addr}, 32'd0);
    check("R2", {30'd0, rd_block, wr_block}, 32'd0);
  endtask

  task automatic run_mode(int mode, int other);
    int n, s;
    do_reset(mode);
    rate_mode = 2'(other);                // R1: ignored after reset
    xfer(1, 0, 0);                        // R3: before sync
    xfer(0, 3, 1);                        // R3: before sync
    pulse();
    n = chans(mode); s = strs(mode);
    for (int f = 0; f < 2; f++) begin
      for (int ch = 0; ch < n; ch++) begin
        for (int st = 0; st < s; st++) xfer(0, ch, st);
        for (int st = 0; st < s; st++) xfer(1, ch, st);
        idle("R11");
      end
    end
    for (int st = 0; st < s; st++) xfer(0, 0, st);   // write tail wraps to last channel
    idle("R11 R1");
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; rate_mode = 0; frame_sync = 0; xfer_vld = 0;
    xfer_is_rd = 0; active_chan = 0; stream_sel = 0;
    run_mode(0, 2);
    run_mode(1, 0);
    run_mode(2, 1);
    run_mode(3, 0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule